// File: doc/BRIEF.md
# Display Contrast and Sleep Command Unit

This unit serves three kinds of run-time request aimed at a graphic LCD controller: change the contrast, put the panel to sleep, and bring it back. Each request is a single-cycle strobe; the contrast strobe carries an 8-bit level. The unit turns each request into a short burst of command bytes and hands them, one at a time, to an external byte shifter. The command/data select line stays low for every byte. The unit drives chip select low around the whole burst.

The controller takes contrast in a 6-bit range, so the 8-bit request is reduced by dropping its two least significant bits. Sleep and wake are fixed three-byte and two-byte sequences. Wake is followed by a settle interval that is counted from the clock frequency. Chip select and busy stay asserted until that interval ends.

When requests meet, wake goes first, then sleep, then contrast. A strobe that arrives while a burst is running is remembered and served after the burst. A repeated contrast strobe before service replaces the stored level. The unit expects to own the serial link whenever busy is high.

Top module: `lcd_ctrl_cmd`

## Requirements
- R1: After reset, lcd_cs_n is high, tx_valid is low and busy is low.
- R2: A contrast request sends byte 0x81 and then the requested level shifted right by two bits (a 0..63 value).
- R3: A sleep request sends 0xAC, 0xAE and 0xA5, in that order.
- R4: A wake request sends 0xA4 and then 0xAF. lcd_cs_n is held low for (CLK_HZ/1000)*SETTLE_MS cycles after the cycle in which the last byte is acknowledged, and only then goes high.
- R5: lcd_a0 is low throughout every burst, so all bytes are commands.
- R6: lcd_cs_n is low whenever tx_valid is high. lcd_cs_n returns high after each request, so each request gets exactly one chip-select low period.
- R7: While tx_valid is high and tx_done is low, tx_valid stays high and tx_byte does not change. tx_done is a one-cycle pulse from the shifter that marks the byte as fully sent.
- R8: Requests that are pending together are served in the order wake, then sleep, then contrast.
- R9: A strobe that arrives while a request is in progress is kept pending and served afterwards. For contrast, the most recent level wins.
- R10: busy is high from the cycle after a request strobe until chip select is released for the last pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_contrast | input | 1 | One-cycle contrast request strobe |
| contrast_level | input | 8 | Requested contrast level, sampled with req_contrast |
| req_sleep | input | 1 | One-cycle sleep request strobe |
| req_wake | input | 1 | One-cycle wake request strobe |
| busy | output | 1 | A request is pending or in progress |
| lcd_cs_n | output | 1 | Controller chip select, active low |
| lcd_a0 | output | 1 | Command/data select, low for command |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_byte | output | 8 | Byte to be shifted |
| tx_done | input | 1 | Shifter finished the offered byte |

## Verification
The embedded assertions cover the properties that hold on every cycle. They check that chip select is low whenever a byte is offered, and that an offered byte stays stable until the shifter acknowledges it. They also check that busy follows any strobe, that an idle unit keeps chip select high, and that the last wake byte leads into the settle wait. The directed scenarios are needed for everything that depends on ordering and content. That covers the exact byte sequences, the scaled contrast value, the settle length measured at the chip-select pin, the priority order among simultaneous requests, and the replacement of a queued contrast level by a later one.

// File: rtl/lcd_ctrl_cmd.sv
module lcd_ctrl_cmd #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETTLE_MS = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_contrast,
  input  logic [7:0] contrast_level,
  input  logic       req_sleep,
  input  logic       req_wake,
  output logic       busy,
  output logic       lcd_cs_n,
  output logic       lcd_a0,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  input  logic       tx_done
);
  localparam int unsigned WAIT_RAW = (CLK_HZ / 1000) * SETTLE_MS;
  localparam int unsigned WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int unsigned CW       = $clog2(WAIT_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SEND, S_HOLD} state_t;
  state_t state;

  logic       pend_w, pend_s, pend_c;
  logic [5:0] pend_lvl;
  logic [7:0] seq [3];
  logic [1:0] idx, last_idx;
  logic       job_wake;
  logic [CW-1:0] hold_cnt;

  wire take     = (state == S_IDLE) && (pend_w || pend_s || pend_c);
  wire byte_end = (state == S_SEND) && tx_done;
  wire last_end = byte_end && (idx == last_idx);

  assign busy     = (state != S_IDLE) || pend_w || pend_s || pend_c;
  assign lcd_cs_n = (state == S_IDLE);
  assign lcd_a0   = 1'b0;
  assign tx_valid = (state == S_SEND);
  assign tx_byte  = seq[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_w   <= 1'b0;
      pend_s   <= 1'b0;
      pend_c   <= 1'b0;
      pend_lvl <= '0;
    end else begin
      if (take) begin
        if (pend_w)      pend_w <= 1'b0;
        else if (pend_s) pend_s <= 1'b0;
        else             pend_c <= 1'b0;
      end
      if (req_wake)  pend_w <= 1'b1;
      if (req_sleep) pend_s <= 1'b1;
      if (req_contrast) begin
        pend_c   <= 1'b1;
        pend_lvl <= contrast_level[7:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      last_idx <= '0;
      job_wake <= 1'b0;
      hold_cnt <= '0;
      seq[0]   <= '0;
      seq[1]   <= '0;
      seq[2]   <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          state <= S_SETUP;
          idx   <= '0;
          if (pend_w) begin
            seq[0] <= 8'hA4; seq[1] <= 8'hAF; seq[2] <= 8'h00;
            last_idx <= 2'd1; job_wake <= 1'b1;
          end else if (pend_s) begin
            seq[0] <= 8'hAC; seq[1] <= 8'hAE; seq[2] <= 8'hA5;
            last_idx <= 2'd2; job_wake <= 1'b0;
          end else begin
            seq[0] <= 8'h81; seq[1] <= {2'b00, pend_lvl}; seq[2] <= 8'h00;
            last_idx <= 2'd1; job_wake <= 1'b0;
          end
        end
        S_SETUP: state <= S_SEND;
        S_SEND: if (byte_end) begin
          if (idx == last_idx) begin
            state    <= job_wake ? S_HOLD : S_IDLE;
            hold_cnt <= '0;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_HOLD: begin
          if (hold_cnt == CW'(WAIT_CYC - 1)) state <= S_IDLE;
          else hold_cnt <= hold_cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  cs_during_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !lcd_cs_n);

  // R7
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_byte)));

  // R10
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lcd_cs_n);

  // R9
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wake || req_sleep || req_contrast) |=> busy);

  // R4
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_end && job_wake) |=> (state == S_HOLD && !lcd_cs_n && busy));
endmodule

// File: tb/lcd_ctrl_cmd_tb_top.sv
module lcd_ctrl_cmd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_HZ = 4000;
  localparam int T_MS = 50;
  localparam int WAITC = (T_HZ / 1000) * T_MS;

  logic clk = 0, rst_n = 0;
  logic req_contrast = 0, req_sleep = 0, req_wake = 0;
  logic [7:0] contrast_level = 0;
  logic busy, lcd_cs_n, lcd_a0, tx_valid, tx_done;
  logic [7:0] tx_byte;

  int checks = 0, failures = 0;
  logic [7:0] logb [32];
  int nlog = 0, cs_falls = 0, a0_bad = 0, cs_bad = 0;
  int lat = 0;
  logic prev_cs = 1;
  int scnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_ctrl_cmd #(.CLK_HZ(T_HZ), .SETTLE_MS(T_MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_contrast(req_contrast),
    .contrast_level(contrast_level), .req_sleep(req_sleep), .req_wake(req_wake),
    .busy(busy), .lcd_cs_n(lcd_cs_n), .lcd_a0(lcd_a0), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_done(tx_done));

  // shifter model: acknowledges each byte after a few cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done <= 0; scnt <= 0;
    end else if (tx_valid && !tx_done) begin
      if (scnt == 3) begin
        tx_done <= 1; scnt <= 0;
        if (nlog < 32) logb[nlog] <= tx_byte;
        nlog <= nlog + 1;
      end else scnt <= scnt + 1;
    end else tx_done <= 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!lcd_cs_n && lcd_a0) a0_bad++;
      if (tx_valid && lcd_cs_n) cs_bad++;
      if (prev_cs && !lcd_cs_n) cs_falls++;
      if (tx_done) lat = 0;
      else if (!lcd_cs_n) lat++;
    end
    prev_cs = lcd_cs_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    nlog = 0; cs_falls = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cs_n", lcd_cs_n, 1);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 busy", busy, 0);
  endtask

  task automatic t_contrast(input logic [7:0] v);
    clear_log();
    req_contrast = 1; contrast_level = v;
    @(negedge clk);
    req_contrast = 0; contrast_level = 8'h00;
    chk("R10 busy after strobe", busy, 1);
    wait_idle();
    chk("R2 count", nlog, 2);
    chk("R2 byte0", logb[0], 8'h81);
    chk("R2 byte1", logb[1], {2'b00, v[7:2]});
    chk("R6 one cs period", cs_falls, 1);
    chk("R6 cs release", lcd_cs_n, 1);
  endtask

  task automatic t_sleep();
    clear_log();
    req_sleep = 1; @(negedge clk); req_sleep = 0;
    wait_idle();
    chk("R3 count", nlog, 3);
    chk("R3 byte0", logb[0], 8'hAC);
    chk("R3 byte1", logb[1], 8'hAE);
    chk("R3 byte2", logb[2], 8'hA5);
  endtask

  task automatic t_wake();
    int lat_cs;
    clear_log();
    req_wake = 1; @(negedge clk); req_wake = 0;
    lat_cs = -1;
    while (nlog < 2) @(negedge clk);
    while (!lcd_cs_n) begin
      @(negedge clk);
      if (lcd_cs_n && lat_cs < 0) lat_cs = lat + 1;
      if (!lcd_cs_n) chk("R10 busy during settle", busy, 1);
    end
    chk("R4 count", nlog, 2);
    chk("R4 byte0", logb[0], 8'hA4);
    chk("R4 byte1", logb[1], 8'hAF);
    // cs rises WAITC cycles after the cycle that consumes the done pulse
    chk("R4 settle length", lat_cs, WAITC + 1);
    @(negedge clk);
    chk("R10 busy low", busy, 0);
  endtask

  task automatic t_priority();
    clear_log();
    req_contrast = 1; contrast_level = 8'h40; req_sleep = 1; req_wake = 1;
    @(negedge clk);
    req_contrast = 0; req_sleep = 0; req_wake = 0;
    wait_idle();
    chk("R8 count", nlog, 7);
    chk("R8 first wake", logb[0], 8'hA4);
    chk("R8 wake end", logb[1], 8'hAF);
    chk("R8 then sleep", logb[2], 8'hAC);
    chk("R8 sleep end", logb[4], 8'hA5);
    chk("R8 then contrast", logb[5], 8'h81);
    chk("R8 contrast val", logb[6], 8'h10);
    chk("R6 three cs periods", cs_falls, 3);
  endtask

  task automatic t_pending();
    clear_log();
    req_sleep = 1; @(negedge clk); req_sleep = 0;
    repeat (3) @(negedge clk);
    req_contrast = 1; contrast_level = 8'h20; @(negedge clk);
    req_contrast = 0;
    repeat (4) @(negedge clk);
    req_contrast = 1; contrast_level = 8'hC8; @(negedge clk);
    req_contrast = 0;
    wait_idle();
    chk("R9 count", nlog, 5);
    chk("R9 sleep first", logb[0], 8'hAC);
    chk("R9 sleep last", logb[2], 8'hA5);
    chk("R9 contrast cmd", logb[3], 8'h81);
    chk("R9 latest level", logb[4], 8'h32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_contrast(8'hFF);
    t_contrast(8'h7B);
    t_contrast(8'h03);
    t_sleep();
    t_wake();
    t_priority();
    t_pending();
    chk("R5 a0 low", a0_bad, 0);
    chk("R6 cs with valid", cs_bad, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule